// File: doc/BRIEF.md
# Receiver PLL Lock-Mode Controller

This block steers a receive clock-recovery PLL between two modes: following a local reference clock, or following the incoming serial data. It waits for a coarse rate detector to report a result, then chooses a mode for that rate.

For standard-definition input the PLL stays on the reference clock indefinitely. For high-definition-class input the PLL is first trained on the reference. Once it reports reference lock, it is released to follow the data. If the link shows no valid signal for a programmable number of cycles, the PLL goes back to reference training and the whole loop starts again.

A fresh rate result that differs from the one in use sends the controller back to waiting for a rate. Both mode outputs are registered and exactly one of them is high at any time.

Top module: `rx_pll_lock_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `lock_to_ref`=1 and `lock_to_data`=0.
- R2: `lock_to_data` never rises unless a `rate_done` pulse has been accepted since reset or since the last rate change. Reference-lock indications alone have no effect while no rate result is present.
- R3: Rate code 0 means SD. After a `rate_done` pulse with code 0, `lock_to_ref` is high on the next cycle and stays high no matter what `pll_locked_ref`, `pll_locked_data` or `sig_valid` do.
- R4: Any nonzero rate code means HD-class. After such a `rate_done` pulse, the controller drives `lock_to_ref`=1 for as long as `pll_locked_ref` stays low.
- R5: In reference training for an HD-class rate, a cycle with `pll_locked_ref`=1 makes `lock_to_data`=1 and `lock_to_ref`=0 on the next cycle. `lock_to_data` rises only after such a cycle.
- R6: While tracking, a cycle with both `sig_valid` and `pll_locked_data` high (and no `rate_done`) keeps `lock_to_data` high on the next cycle.
- R7: While tracking, the no-signal counter counts every cycle in which `sig_valid` or `pll_locked_data` is low, and clears on any cycle in which both are high. On the TIMEOUT_CYCLES-th consecutive counted cycle the outputs switch to `lock_to_ref`=1. The next cycle re-enters reference training, and the train-then-track sequence repeats.
- R8: A `rate_done` pulse carrying a code equal to the one in use is ignored. A pulse with a different code, seen while training, tracking or retraining, returns the controller to waiting for a rate with `lock_to_ref`=1. The code is only adopted from a later `rate_done` pulse.
- R9: `lock_to_ref` and `lock_to_data` are never both high and never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | RATE_W | Detected rate; 0 = SD, nonzero = HD-class |
| rate_done | input | 1 | One-cycle pulse: `rate_code` is valid |
| pll_locked_ref | input | 1 | PLL reports lock to the reference clock |
| pll_locked_data | input | 1 | PLL reports lock to the incoming data |
| sig_valid | input | 1 | Framing logic sees a valid signal |
| lock_to_ref | output | 1 | Command: PLL follows the reference clock |
| lock_to_data | output | 1 | Command: PLL follows the data |

## Verification
The bench runs an SD result with reference lock and no valid signal held well past the timeout. Because the outputs never move, this separates the SD hold from HD training. An HD result is then given with reference lock first withheld and then granted, which shows that the release waits for lock. In tracking, a long valid run, a run of invalid cycles broken by one valid cycle, and an exact run of TIMEOUT_CYCLES invalid cycles tell apart a correct clear, a counter that never clears, and an off-by-one expiry; the last run also shows that a lost data lock counts as invalid. Same-code and different-code rate pulses in several states separate ignoring a repeat from reacting to a real rate change.

// File: rtl/rx_pll_lock_pkg.sv
package rx_pll_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_RATE  = 3'd1,
    ST_LOCK_REF   = 3'd2,
    ST_TRACK_DATA = 3'd3,
    ST_RETRAIN    = 3'd4
  } lock_state_t;

  function automatic logic drives_data(input lock_state_t s);
    return (s == ST_TRACK_DATA);
  endfunction

endpackage

// File: rtl/rpl_rate_capture.sv
module rpl_rate_capture #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_en,
  input  logic              rate_done,
  input  logic [RATE_W-1:0] rate_code,
  output logic              held_is_sd,
  output logic              rate_changed
);

  localparam logic [RATE_W-1:0] SD_CODE = '0;

  logic [RATE_W-1:0] held_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_code <= SD_CODE;
    end else if (capture_en) begin
      held_code <= rate_code;
    end
  end

  assign held_is_sd   = (held_code == SD_CODE);
  assign rate_changed = rate_done && (rate_code != held_code);

endmodule

// File: rtl/rpl_signal_timer.sv
module rpl_signal_timer #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sig_ok,
  output logic expired
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = run && !sig_ok && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || sig_ok || expired) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rpl_lock_fsm.sv
module rpl_lock_fsm
  import rx_pll_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rate_done,
  input  logic        rate_changed,
  input  logic        held_is_sd,
  input  logic        pll_locked_ref,
  input  logic        expired,
  output lock_state_t state,
  output logic        lock_to_ref,
  output logic        lock_to_data
);

  lock_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      nxt = ST_WAIT_RATE;
      ST_WAIT_RATE: if (rate_done) nxt = ST_LOCK_REF;
      ST_LOCK_REF: begin
        if (rate_changed)                    nxt = ST_WAIT_RATE;
        else if (!held_is_sd && pll_locked_ref) nxt = ST_TRACK_DATA;
      end
      ST_TRACK_DATA: begin
        if (rate_changed) nxt = ST_WAIT_RATE;
        else if (expired) nxt = ST_RETRAIN;
      end
      ST_RETRAIN: begin
        if (rate_changed) nxt = ST_WAIT_RATE;
        else              nxt = ST_LOCK_REF;
      end
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      lock_to_ref  <= 1'b1;
      lock_to_data <= 1'b0;
    end else begin
      state        <= nxt;
      lock_to_ref  <= !drives_data(nxt);
      lock_to_data <= drives_data(nxt);
    end
  end

endmodule

// File: rtl/rx_pll_lock_ctrl.sv
module rx_pll_lock_ctrl
  import rx_pll_lock_pkg::*;
#(
  parameter int RATE_W         = 2,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rate_done,
  input  logic              pll_locked_ref,
  input  logic              pll_locked_data,
  input  logic              sig_valid,
  output logic              lock_to_ref,
  output logic              lock_to_data
);

  lock_state_t state;
  logic        held_is_sd;
  logic        rate_changed;
  logic        expired;
  logic        capture_en;
  logic        track_run;

  assign capture_en = (state == ST_WAIT_RATE) && rate_done;
  assign track_run  = (state == ST_TRACK_DATA);

  rpl_rate_capture #(.RATE_W(RATE_W)) u_rate (
    .clk          (clk),
    .rst          (rst),
    .capture_en   (capture_en),
    .rate_done    (rate_done),
    .rate_code    (rate_code),
    .held_is_sd   (held_is_sd),
    .rate_changed (rate_changed)
  );

  rpl_signal_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (track_run),
    .sig_ok  (sig_valid && pll_locked_data),
    .expired (expired)
  );

  rpl_lock_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .rate_done      (rate_done),
    .rate_changed   (rate_changed),
    .held_is_sd     (held_is_sd),
    .pll_locked_ref (pll_locked_ref),
    .expired        (expired),
    .state          (state),
    .lock_to_ref    (lock_to_ref),
    .lock_to_data   (lock_to_data)
  );

endmodule

// File: rtl/rpl_lock_checker.sv
module rpl_lock_checker #(
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] rate_code,
  input logic              rate_done,
  input logic              pll_locked_ref,
  input logic              pll_locked_data,
  input logic              sig_valid,
  input logic              lock_to_ref,
  input logic              lock_to_data
);

  logic              past_rst;
  logic [RATE_W-1:0] last_code;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst)            last_code <= '0;
    else if (rate_done) last_code <= rate_code;
  end

  always_ff @(posedge clk) begin
    if (past_rst) begin
      assert_reset_state_R1: assert (lock_to_ref && !lock_to_data)
        else $error("reset output state wrong");
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    lock_to_ref != lock_to_data);

  assert_sd_holds_ref_R3: assert property (@(posedge clk) disable iff (rst)
    (rate_done && rate_code == '0) |=> lock_to_ref);

  assert_release_after_lock_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_to_data) |-> $past(pll_locked_ref));

  assert_valid_keeps_track_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_to_data && sig_valid && pll_locked_data && !rate_done) |=> lock_to_data);

  assert_rate_change_exits_R8: assert property (@(posedge clk) disable iff (rst)
    (lock_to_data && rate_done && rate_code != last_code) |=> lock_to_ref);

endmodule

bind rx_pll_lock_ctrl rpl_lock_checker #(.RATE_W(RATE_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .rate_code       (rate_code),
  .rate_done       (rate_done),
  .pll_locked_ref  (pll_locked_ref),
  .pll_locked_data (pll_locked_data),
  .sig_valid       (sig_valid),
  .lock_to_ref     (lock_to_ref),
  .lock_to_data    (lock_to_data)
);

// File: tb/rx_pll_lock_ctrl_tb.sv
module rx_pll_lock_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RATE_W     = 2;
  localparam int TMO        = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [RATE_W-1:0] rate_code = '0;
  logic              rate_done = 1'b0;
  logic              pll_locked_ref = 1'b0;
  logic              pll_locked_data = 1'b0;
  logic              sig_valid = 1'b0;
  logic              lock_to_ref;
  logic              lock_to_data;

  typedef struct {
    bit    eref;
    bit    edata;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  bit   done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pll_lock_ctrl #(.RATE_W(RATE_W), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk             (clk),
    .rst             (rst),
    .rate_code       (rate_code),
    .rate_done       (rate_done),
    .pll_locked_ref  (pll_locked_ref),
    .pll_locked_data (pll_locked_data),
    .sig_valid       (sig_valid),
    .lock_to_ref     (lock_to_ref),
    .lock_to_data    (lock_to_data)
  );

  // Driver: applies one cycle of inputs and queues the outputs expected after the next edge.
  task automatic drive(input bit r, input bit dn, input logic [RATE_W-1:0] code,
                       input bit lr, input bit ld, input bit sv,
                       input bit eref, input bit edata, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; rate_done = dn; rate_code = code;
    pll_locked_ref = lr; pll_locked_data = ld; sig_valid = sv;
    e.eref = eref; e.edata = edata; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (lock_to_ref !== cur.eref || lock_to_data !== cur.edata) begin
        errors++;
        $display("FAIL %s: ref/data = %b/%b, expected %b/%b",
                 cur.tag, lock_to_ref, lock_to_data, cur.eref, cur.edata);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) drive(1, 0, 0, 0, 0, 0, 1, 0, "R1 reset");
    drive(0, 0, 0, 0, 0, 0, 1, 0, "R1 first cycle after reset");
    // R2 reference lock without a rate result does nothing
    repeat (3) drive(0, 0, 0, 1, 1, 1, 1, 0, "R2 no rate yet");
    // R3 SD code 0 holds reference beyond the timeout
    drive(0, 1, 0, 1, 0, 0, 1, 0, "R3 SD accepted");
    for (int i = 0; i < 3 * TMO; i++) drive(0, 0, 0, 1, i[0], i[1], 1, 0, "R3 SD hold");
    drive(0, 1, 0, 1, 0, 0, 1, 0, "R8 same SD code ignored");
    // R8 different code returns to waiting
    drive(0, 1, 1, 1, 0, 0, 1, 0, "R8 rate change from SD");
    drive(0, 0, 1, 1, 1, 1, 1, 0, "R2 waiting after change");
    // R4 HD training waits for reference lock
    drive(0, 1, 1, 0, 0, 0, 1, 0, "R4 HD accepted");
    repeat (3) drive(0, 0, 1, 0, 0, 0, 1, 0, "R4 training");
    // R5 release on reference lock
    drive(0, 0, 1, 1, 1, 1, 0, 1, "R5 release to data");
    // R6 valid signal keeps tracking
    for (int i = 0; i < 2 * TMO; i++) drive(0, 0, 1, 0, 1, 1, 0, 1, "R6 tracking valid");
    drive(0, 1, 1, 0, 1, 1, 0, 1, "R8 same HD code ignored");
    // R7 counter clears on a valid cycle, then expires exactly
    repeat (TMO - 3) drive(0, 0, 1, 0, 1, 0, 0, 1, "R7 invalid run");
    drive(0, 0, 1, 0, 1, 1, 0, 1, "R7 clearing cycle");
    repeat (TMO - 1) drive(0, 0, 1, 0, 0, 1, 0, 1, "R7 data lock lost, below limit");
    drive(0, 0, 1, 0, 0, 1, 1, 0, "R7 timeout retrain");
    drive(0, 0, 1, 0, 0, 0, 1, 0, "R7 retrain to training");
    drive(0, 0, 1, 0, 0, 0, 1, 0, "R7 training again");
    drive(0, 0, 1, 1, 1, 1, 0, 1, "R7 tracking again");
    // R8 rate change while tracking
    drive(0, 1, 2, 1, 1, 1, 1, 0, "R8 rate change from HD");
    drive(0, 0, 2, 1, 1, 1, 1, 0, "R2 waiting holds reference");
    drive(0, 1, 2, 1, 1, 1, 1, 0, "R8 new code adopted");
    drive(0, 0, 2, 1, 1, 1, 0, 1, "R5 release for new code");
    drive(0, 0, 2, 0, 1, 1, 0, 1, "R9 single command");
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule